// File: doc/BRIEF.md
# Lockable two-stage watchdog timer

This block is a memory-mapped watchdog for a chip's peripheral space. Software programs a reload value, enables counting and, optionally, reset generation, then keeps the system alive by writing to an acknowledge register before the count runs out a second time. A down-counter advances only on cycles where an external tick-enable input is high, so a clock divider outside the block sets the real time base.

Each timeout spans two full count periods. When the counter first passes through zero, the block raises an interrupt and starts the count again from the reload value. If the interrupt has not been acknowledged when the counter next reaches zero, and reset generation is enabled, the block raises a reset request. That request stays high until the block itself is reset.

All configuration writes are blocked until a 32-bit key is written to a guard register. Any other value written there closes the guard again. This guards against stray writes disabling the watchdog.

Top module: `wdog_timer`

## Requirements
- R1: After reset the guard reads 1 (locked), the control register reads 0, the reload register reads 0xFFFFFFFF, and both the interrupt and the reset request are low.
- R2: Writing 0x1ACCE551 to the guard register at byte offset 0xC00 opens it, and it then reads 0. Writing any other value closes it, and it then reads 1. The guard register accepts writes whether it is open or closed.
- R3: While the guard is closed, writes to the reload register (offset 0x000), the control register (offset 0x008) and the acknowledge register (offset 0x00C) have no effect: readback, the interrupt and the counting are unchanged.
- R4: An accepted write to the reload register stores the value, which reads back at offset 0x000, and restarts the count from that value on the next cycle.
- R5: The counter changes only on cycles where tick enable is high and control bit 0 is set. A reload value N gives an expiry on the (N+1)-th such tick.
- R6: At an expiry with no interrupt pending, the interrupt output goes high after that clock edge and the count restarts from the reload value.
- R7: At an expiry with the interrupt already pending and control bit 1 set, the reset request goes high after that edge. It stays high until the block's own reset.
- R8: Any accepted write to the acknowledge register clears the pending interrupt and restarts the count from the reload value. The clear takes priority over an expiry in the same cycle, so acknowledging in time prevents the reset request.
- R9: With control bit 1 clear, a second expiry leaves the reset request low and the interrupt stays pending.
- R10: Writing 0 to the control register halts the counter, so no further expiry occurs however many ticks arrive.
- R11: Reads return the guard state at 0xC00, control bits [1:0] at 0x008 and the reload value at 0x000. The acknowledge offset and every unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable from an external prescaler |
| busAddr | input | 12 | Register byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the addressed register |
| irqOut | output | 1 | Interrupt: first expiry not yet acknowledged |
| rstReqOut | output | 1 | Sticky reset request |

## Verification
A register write takes effect at the clock edge that samples it, so new readback, guard state and restarted counts are visible in the half-cycle after that edge. Read data is combinational: the bench checks it while the address is held, before the next edge. An expiry needs N+1 qualifying ticks; the interrupt or the reset request is due in the half-cycle after the edge that consumed the final tick. The bench steps one cycle at a time and compares both outputs against its cycle-accurate model at each falling edge. This way, no expiry result is sampled one cycle early or late.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 2;
  localparam int OFS_LOAD = 'h000;
  localparam int OFS_CTRL = 'h008;
  localparam int OFS_ACK  = 'h00C;
  localparam int OFS_LOCK = 'hC00;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  // strobes from the register file to the counter datapath
  typedef struct packed {
    logic              reload;
    logic              clearIrq;
    logic [DATA_W-1:0] reloadVal;
  } wdogStrobeT;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output wdogStrobeT        stb,
  output logic              cntEn,
  output logic              rstEn,
  output logic [DATA_W-1:0] loadVal
);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);

  logic [DATA_W-1:0] loadReg;
  logic [CTRL_W-1:0] ctrlReg;
  logic              locked;
  logic              hitLoad, hitCtrl, hitAck, hitLock;
  logic              wrOpen;

  assign hitLoad = (busAddr == A_LOAD);
  assign hitCtrl = (busAddr == A_CTRL);
  assign hitAck  = (busAddr == A_ACK);
  assign hitLock = (busAddr == A_LOCK);
  assign wrOpen  = busWe && !locked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadReg <= '1;
      ctrlReg <= '0;
      locked  <= 1'b1;
    end else begin
      if (busWe && hitLock) locked <= (busWdata != UNLOCK_KEY);
      if (wrOpen && hitLoad) loadReg <= busWdata;
      if (wrOpen && hitCtrl) ctrlReg <= busWdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    stb.reload    = wrOpen && (hitLoad || hitAck);
    stb.clearIrq  = wrOpen && hitAck;
    stb.reloadVal = hitLoad ? busWdata : loadReg;
  end

  assign cntEn   = ctrlReg[0];
  assign rstEn   = ctrlReg[1];
  assign loadVal = loadReg;

  always_comb begin
    busRdata = '0;
    if (hitLoad)      busRdata = loadReg;
    else if (hitCtrl) busRdata = DATA_W'(ctrlReg);
    else if (hitLock) busRdata = DATA_W'(locked);
  end

  AST_LOCKED_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(loadReg)); // R3
  AST_LOCKED_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(ctrlReg)); // R3
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && hitLock && busWdata == UNLOCK_KEY) |=> !locked); // R2
  AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && hitLock && busWdata != UNLOCK_KEY) |=> locked); // R2
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  wdogStrobeT        stb,
  input  logic              cntEn,
  input  logic              rstEn,
  input  logic [DATA_W-1:0] loadVal,
  output logic              irqPending,
  output logic              rstReq
);
  logic [DATA_W-1:0] count;
  logic              atZero;
  logic              expire;

  assign atZero = (count == '0);
  assign expire = !stb.reload && cntEn && tickEn && atZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '1;
    end else if (stb.reload) begin
      count <= stb.reloadVal;
    end else if (cntEn && tickEn) begin
      count <= atZero ? loadVal : count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPending <= 1'b0;
      rstReq     <= 1'b0;
    end else begin
      if (stb.clearIrq)                irqPending <= 1'b0;
      else if (expire && !irqPending)  irqPending <= 1'b1;
      if (expire && irqPending && rstEn) rstReq <= 1'b1;
    end
  end

  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> rstReq); // R7
  AST_RST_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> $past(irqPending)); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearIrq |=> !irqPending); // R8
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !stb.reload) |=> $stable(count)); // R10
  AST_EXPIRY_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (count == $past(loadVal))); // R6
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              rstReqOut
);
  wdogStrobeT        stb;
  logic              cntEn, rstEn;
  logic [DATA_W-1:0] loadVal;

  wdog_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .stb(stb),
    .cntEn(cntEn), .rstEn(rstEn), .loadVal(loadVal)
  );

  wdog_datapath dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .stb(stb),
    .cntEn(cntEn), .rstEn(rstEn), .loadVal(loadVal),
    .irqPending(irqOut), .rstReq(rstReqOut)
  );
endmodule

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;
  localparam logic [11:0] A_LOAD = 12'h000;
  localparam logic [11:0] A_CTRL = 12'h008;
  localparam logic [11:0] A_ACK  = 12'h00C;
  localparam logic [11:0] A_LOCK = 12'hC00;
  localparam logic [31:0] KEY    = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, rstReqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] mLoad, mCount;
  logic [1:0]  mCtrl;
  logic        mLocked, mIrq, mRst;

  always #2 clk = ~clk;

  wdog_timer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(logic [11:0] a);
    if (a == A_LOAD) return mLoad;
    if (a == A_CTRL) return {30'b0, mCtrl};
    if (a == A_LOCK) return {31'b0, mLocked};
    return 32'h0;
  endfunction

  task automatic modelStep(logic [11:0] a, logic we, logic [31:0] d, logic tk);
    logic open;
    open = we && !mLocked;
    if (open && a == A_LOAD) begin
      mLoad = d; mCount = d;
    end else if (open && a == A_ACK) begin
      mCount = mLoad; mIrq = 1'b0;
    end else if (mCtrl[0] && tk) begin
      if (mCount == 0) begin
        mCount = mLoad;
        if (!mIrq) mIrq = 1'b1;
        else if (mCtrl[1]) mRst = 1'b1;
      end else mCount = mCount - 1;
    end
    if (open && a == A_CTRL) mCtrl = d[1:0];
    if (we && a == A_LOCK) mLocked = (d != KEY);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(logic [11:0] a, logic we, logic [31:0] d, logic tk, string tag);
    busAddr = a; busWe = we; busWdata = d; tickEn = tk;
    @(posedge clk);
    modelStep(a, we, d, tk);
    @(negedge clk);
    busWe = 1'b0; tickEn = 1'b0;
    chk({tag, " R6 irq"}, {31'b0, irqOut}, {31'b0, mIrq});
    chk({tag, " R7 rstReq"}, {31'b0, rstReqOut}, {31'b0, mRst});
  endtask

  task automatic readChk(logic [11:0] a, string tag);
    busAddr = a; busWe = 1'b0; tickEn = 1'b0;
    #1;
    chk({tag, " R11 read"}, busRdata, expRead(a));
    @(negedge clk);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) step(A_LOAD, 1'b0, 32'h0, 1'b1, tag);
  endtask

  task automatic doReset();
    rstN = 1'b0; busWe = 1'b0; tickEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mLoad = '1; mCount = '1; mCtrl = '0; mLocked = 1'b1; mIrq = 1'b0; mRst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    // R1 reset state
    readChk(A_LOCK, "R1 lock");
    readChk(A_CTRL, "R1 ctrl");
    readChk(A_LOAD, "R1 load");
    chk("R1 irq low", {31'b0, irqOut}, 32'h0);
    chk("R1 rst low", {31'b0, rstReqOut}, 32'h0);
    // R3 locked writes ignored
    step(A_LOAD, 1'b1, 32'h5, 1'b0, "R3 locked load");
    readChk(A_LOAD, "R3 load unchanged");
    step(A_CTRL, 1'b1, 32'h3, 1'b0, "R3 locked ctrl");
    readChk(A_CTRL, "R3 ctrl unchanged");
    // R2 open and close
    step(A_LOCK, 1'b1, KEY, 1'b0, "R2 key");
    readChk(A_LOCK, "R2 open");
    chk("R2 open reads 0", busRdata, 32'h0);
    step(A_LOCK, 1'b1, 32'h1, 1'b0, "R2 close");
    readChk(A_LOCK, "R2 closed");
    chk("R2 closed reads 1", busRdata, 32'h1);
    step(A_LOCK, 1'b1, KEY, 1'b0, "R2 reopen");
    // R4 load write and readback
    step(A_LOAD, 1'b1, 32'h3, 1'b0, "R4 load");
    readChk(A_LOAD, "R4 readback");
    chk("R4 load is 3", busRdata, 32'h3);
    step(A_CTRL, 1'b1, 32'h3, 1'b0, "R5 arm");
    // R5: load 3 => expiry on 4th tick
    ticks(3, "R5 pre-expiry");
    chk("R5 irq low after 3 ticks", {31'b0, irqOut}, 32'h0);
    step(A_LOAD, 1'b0, 0, 1'b0, "R5 no tick");
    step(A_LOAD, 1'b0, 0, 1'b0, "R5 no tick");
    ticks(1, "R6 expiry");
    chk("R6 irq high on 4th tick", {31'b0, irqOut}, 32'h1);
    // R8 ack clears and reloads, prevents reset
    ticks(2, "R8 mid");
    step(A_ACK, 1'b1, 32'hDEAD, 1'b1, "R8 ack");
    chk("R8 irq cleared", {31'b0, irqOut}, 32'h0);
    ticks(4, "R8 refire");
    chk("R8 irq again", {31'b0, irqOut}, 32'h1);
    chk("R8 no reset yet", {31'b0, rstReqOut}, 32'h0);
    // R7 second expiry
    ticks(3, "R7 pre");
    chk("R7 rst low before", {31'b0, rstReqOut}, 32'h0);
    ticks(1, "R7 second");
    chk("R7 rst high", {31'b0, rstReqOut}, 32'h1);
    step(A_CTRL, 1'b1, 32'h0, 1'b0, "R7 stop");
    step(A_ACK, 1'b1, 32'h0, 1'b0, "R7 ack");
    chk("R7 rst sticky", {31'b0, rstReqOut}, 32'h1);
    // R3 locked ack ignored
    doReset();
    step(A_LOCK, 1'b1, KEY, 1'b0, "R3 key");
    step(A_LOAD, 1'b1, 32'h1, 1'b0, "R9 load");
    step(A_CTRL, 1'b1, 32'h1, 1'b0, "R9 irq only");
    ticks(2, "R9 first");
    chk("R9 irq", {31'b0, irqOut}, 32'h1);
    ticks(2, "R9 second");
    chk("R9 no reset", {31'b0, rstReqOut}, 32'h0);
    chk("R9 irq stays", {31'b0, irqOut}, 32'h1);
    step(A_LOCK, 1'b1, 32'h0, 1'b0, "R3 close");
    step(A_ACK, 1'b1, 32'h0, 1'b0, "R3 locked ack");
    chk("R3 irq kept", {31'b0, irqOut}, 32'h1);
    // R10 halt
    step(A_LOCK, 1'b1, KEY, 1'b0, "R10 key");
    step(A_ACK, 1'b1, 32'h0, 1'b0, "R10 ack");
    step(A_CTRL, 1'b1, 32'h0, 1'b0, "R10 stop");
    ticks(10, "R10 halted");
    chk("R10 no irq", {31'b0, irqOut}, 32'h0);
    // R11 ack and unmapped offsets read 0
    readChk(A_ACK, "R11 ack");
    readChk(12'h004, "R11 unmapped");
    readChk(12'h7F0, "R11 unmapped");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      if (i % 500 == 0) doReset();
      r = int'($urandom % 16);
      if (r < 9)       step(A_LOAD, 1'b0, 0, ($urandom % 4) != 0, "R5 rnd tick");
      else if (r == 9) step(A_LOAD, 1'b1, $urandom % 6, $urandom % 2, "R4 rnd load");
      else if (r == 10) step(A_CTRL, 1'b1, $urandom, $urandom % 2, "R10 rnd ctrl");
      else if (r == 11) step(A_ACK, 1'b1, $urandom, $urandom % 2, "R8 rnd ack");
      else if (r == 12) step(A_LOCK, 1'b1, KEY, $urandom % 2, "R2 rnd key");
      else if (r == 13) step(A_LOCK, 1'b1, $urandom, $urandom % 2, "R2 rnd close");
      else if (r == 14) begin
        logic [11:0] ra;
        case ($urandom % 5)
          0: ra = A_LOAD; 1: ra = A_CTRL; 2: ra = A_ACK; 3: ra = A_LOCK;
          default: ra = 12'($urandom);
        endcase
        readChk(ra, "R11 rnd");
      end else step(12'($urandom), 1'b1, $urandom, $urandom % 2, "R3 rnd stray");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule